// File: doc/BRIEF.md
# Branch Trail Stack

This block records the most recent retired branches of a processor for a trace or debug unit. Each retired branch arrives as one event carrying its source address, its target address, a three-bit kind code and a privilege flag. A software-written select register decides which kinds and privilege levels are kept. Kept branches go into a sixteen-entry store that software can read back one entry at a time. A top index and a record count are visible at all times.

In ring mode every kept branch becomes a new record and the oldest record is overwritten once the store is full. In call-chain mode only calls add a record, and each kept return removes the newest record. The store then holds the live chain of callers, and branches made inside leaf functions leave no trace.

Two stall inputs exist. A debugger hold stops all updates in both modes. An interrupt-driven hold stops updates only in ring mode; it is ignored in call-chain mode because a hold that lands between a call and its return would unbalance the chain.

Top module: `branch_trail_stack`

## Requirements
- R1: After reset the top index is 15, the record count is 0, every entry reads back with its valid flag at 0, and the select register is 0.
- R2: Select bits 0 to 8 each suppress one category when set. Bit 0 suppresses branches with kernel privilege (br_user=0) and bit 1 those with user privilege (br_user=1). Kind codes map as follows: 0 conditional uses bit 2, 3 relative call uses bit 3, 4 indirect call uses bit 4, 5 return uses bit 5, 2 indirect jump uses bit 6, 1 relative jump uses bit 7, and 6 far branch uses bit 8. Kind code 7 is never recorded. A select write takes effect from the next cycle.
- R3: In ring mode (select bit 9 clear), a kept branch writes its source, its target and a set valid flag into entry (top+1) mod 16. The top index moves to that entry and the count rises by one, saturating at 16, so the oldest entry is overwritten.
- R4: In ring mode a kept return (kind 5) is recorded like any other branch and never removes a record.
- R5: In call-chain mode (select bit 9 set), a kept call (kind 3 or 4) is recorded exactly as in R3.
- R6: In call-chain mode, a kept return with a nonzero count clears the valid flag of the entry at the top index and leaves its addresses in place. The top index then steps back by one modulo 16 and the count drops by one.
- R7: In call-chain mode, a return that arrives while the count is 0 changes neither the top index, nor the count, nor any entry.
- R8: In call-chain mode, conditional branches, jumps and far branches (kinds 0, 1, 2, 6) are never recorded, whatever the select bits.
- R9: While freeze is high no event changes the top index, the count or any entry, and reads keep working.
- R10: While irq_freeze is high, events are dropped in ring mode. In call-chain mode irq_freeze has no effect.
- R11: The entry named by rd_idx at a clock edge appears on rd_from, rd_to and rd_vld after that edge. It shows the contents from before any update made at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | A retired branch is presented this cycle |
| br_from | input | AW | Branch source address |
| br_to | input | AW | Branch target address |
| br_kind | input | 3 | Branch kind code (see R2) |
| br_user | input | 1 | 1 = user privilege, 0 = kernel privilege |
| sel_we | input | 1 | Write strobe for the select register |
| sel_wdata | input | 10 | New select value (bits 0-8 suppress, bit 9 call-chain mode) |
| freeze | input | 1 | Debugger hold, honoured in both modes |
| irq_freeze | input | 1 | Interrupt hold, honoured in ring mode only |
| rd_idx | input | log2(DEPTH) | Entry to read |
| rd_from | output | AW | Source address of the entry read |
| rd_to | output | AW | Target address of the entry read |
| rd_vld | output | 1 | Valid flag of the entry read |
| top_idx | output | log2(DEPTH) | Index of the newest record |
| rec_count | output | log2(DEPTH+1) | Number of valid records, 0 to DEPTH |

## Verification
The hardest state to reach from the ports is a call chain that has overflowed the store: the count sits at 16, the top index has wrapped, and returns then walk the index back past entry 0 into entry 15 until the count reaches zero, after which one further return must be ignored. A directed burst of eighteen calls followed by sixteen returns and one extra return drives exactly this path. Random phases then switch between ring and call-chain select values and bias the kinds toward calls and returns, so that pushes and pops interleave with freezes, suppressed categories and mode changes. A bench model predicts every top index, count and read-back value.

// File: rtl/bts_pkg.sv
package bts_pkg;

    localparam int SEL_W     = 10;
    localparam int SB_KERN   = 0;
    localparam int SB_USER   = 1;
    localparam int SB_COND   = 2;
    localparam int SB_RCALL  = 3;
    localparam int SB_ICALL  = 4;
    localparam int SB_RET    = 5;
    localparam int SB_IJMP   = 6;
    localparam int SB_RJMP   = 7;
    localparam int SB_FAR    = 8;
    localparam int SB_CHAIN  = 9;

    typedef enum logic [2:0] {
        BK_COND  = 3'd0,
        BK_RJMP  = 3'd1,
        BK_IJMP  = 3'd2,
        BK_RCALL = 3'd3,
        BK_ICALL = 3'd4,
        BK_RET   = 3'd5,
        BK_FAR   = 3'd6,
        BK_NONE  = 3'd7
    } br_kind_e;

    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,
        ACT_PUSH = 2'd1,
        ACT_POP  = 2'd2
    } stk_act_e;

endpackage

// File: rtl/bts_filter.sv
module bts_filter
    import bts_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             br_valid,
    input  logic [2:0]       br_kind,
    input  logic             br_user,
    input  logic             freeze,
    input  logic             irq_freeze,
    output stk_act_e         act
);

    br_kind_e kind;
    logic     kind_supp;
    logic     priv_supp;
    logic     chain_mode;
    logic     halted;
    logic     take;
    logic     is_call;
    logic     is_ret;
    logic     is_flow;

    always_comb begin
        kind = br_kind_e'(br_kind);
        case (kind)
            BK_COND:  kind_supp = sel[SB_COND];
            BK_RJMP:  kind_supp = sel[SB_RJMP];
            BK_IJMP:  kind_supp = sel[SB_IJMP];
            BK_RCALL: kind_supp = sel[SB_RCALL];
            BK_ICALL: kind_supp = sel[SB_ICALL];
            BK_RET:   kind_supp = sel[SB_RET];
            BK_FAR:   kind_supp = sel[SB_FAR];
            default:  kind_supp = 1'b1;
        endcase
        priv_supp  = br_user ? sel[SB_USER] : sel[SB_KERN];
        chain_mode = sel[SB_CHAIN];
        // interrupt hold is ignored in call-chain mode to keep the chain balanced
        halted     = freeze | (irq_freeze & ~chain_mode);
        take       = br_valid & ~halted & ~kind_supp & ~priv_supp;
        is_call    = (kind == BK_RCALL) | (kind == BK_ICALL);
        is_ret     = (kind == BK_RET);
        is_flow    = (kind == BK_COND) | (kind == BK_RJMP) | (kind == BK_IJMP) | (kind == BK_FAR);

        act = ACT_IDLE;
        if (take) begin
            if (chain_mode) begin
                if (is_call) begin
                    act = ACT_PUSH;
                end else if (is_ret) begin
                    act = ACT_POP;
                end
            end else begin
                act = ACT_PUSH;
            end
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |-> act == ACT_IDLE); // R9
    AST_CHAIN_FLOW_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (sel[SB_CHAIN] && is_flow) |-> act == ACT_IDLE); // R8
    AST_RING_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        !sel[SB_CHAIN] |-> act != ACT_POP); // R4

endmodule

// File: rtl/bts_pointer.sv
module bts_pointer
    import bts_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int IW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  stk_act_e      act,
    output logic [IW-1:0] top_o,
    output logic [CW-1:0] cnt_o,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic          clr_en,
    output logic [IW-1:0] clr_idx
);

    localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [IW-1:0] top;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t st_d;
    ptr_t st_q;

    always_comb begin
        st_d    = st_q;
        wr_en   = 1'b0;
        wr_idx  = st_q.top;
        clr_en  = 1'b0;
        clr_idx = st_q.top;
        case (act)
            ACT_PUSH: begin
                st_d.top = (st_q.top == LAST) ? '0 : st_q.top + IW'(1);
                if (st_q.cnt != FULL) begin
                    st_d.cnt = st_q.cnt + CW'(1);
                end
                wr_en  = 1'b1;
                wr_idx = st_d.top;
            end
            ACT_POP: begin
                if (st_q.cnt != '0) begin
                    clr_en   = 1'b1;
                    st_d.top = (st_q.top == '0) ? LAST : st_q.top - IW'(1);
                    st_d.cnt = st_q.cnt - CW'(1);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.top <= LAST;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign top_o = st_q.top;
    assign cnt_o = st_q.cnt;

    AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL); // R3
    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        act == ACT_PUSH |=> st_q.top == (($past(st_q.top) == LAST) ? '0 : $past(st_q.top) + IW'(1))); // R3
    AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_POP && st_q.cnt != '0) |=> st_q.cnt == $past(st_q.cnt) - CW'(1)); // R6
    AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_POP && st_q.cnt == '0) |=> ($stable(st_q.top) && st_q.cnt == '0)); // R7

endmodule

// File: rtl/bts_entries.sv
module bts_entries #(
    parameter  int AW    = 32,
    parameter  int DEPTH = 16,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [AW-1:0] wr_from,
    input  logic [AW-1:0] wr_to,
    input  logic          clr_en,
    input  logic [IW-1:0] clr_idx,
    input  logic [IW-1:0] rd_idx,
    output logic [AW-1:0] rd_from,
    output logic [AW-1:0] rd_to,
    output logic          rd_vld
);

    typedef struct packed {
        logic [AW-1:0] from_a;
        logic [AW-1:0] to_a;
        logic          vld;
    } ent_t;

    ent_t ent_view [DEPTH];
    ent_t rd_d;
    ent_t rd_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        ent_t e_d;
        ent_t e_q;

        always_comb begin
            e_d = e_q;
            if (wr_en && wr_idx == IW'(g)) begin
                e_d.from_a = wr_from;
                e_d.to_a   = wr_to;
                e_d.vld    = 1'b1;
            end else if (clr_en && clr_idx == IW'(g)) begin
                e_d.vld = 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                e_q <= '0;
            end else begin
                e_q <= e_d;
            end
        end

        assign ent_view[g] = e_q;
    end

    always_comb begin
        rd_d = ent_view[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_from = rd_q.from_a;
    assign rd_to   = rd_q.to_a;
    assign rd_vld  = rd_q.vld;

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ent_view[$past(wr_idx)].vld && ent_view[$past(wr_idx)].from_a == $past(wr_from))); // R3
    AST_CLEAR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !wr_en) |=> !ent_view[$past(clr_idx)].vld); // R6

endmodule

// File: rtl/branch_trail_stack.sv
module branch_trail_stack
    import bts_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       br_valid,
    input  logic [AW-1:0]              br_from,
    input  logic [AW-1:0]              br_to,
    input  logic [2:0]                 br_kind,
    input  logic                       br_user,
    input  logic                       sel_we,
    input  logic [9:0]                 sel_wdata,
    input  logic                       freeze,
    input  logic                       irq_freeze,
    input  logic [$clog2(DEPTH)-1:0]   rd_idx,
    output logic [AW-1:0]              rd_from,
    output logic [AW-1:0]              rd_to,
    output logic                       rd_vld,
    output logic [$clog2(DEPTH)-1:0]   top_idx,
    output logic [$clog2(DEPTH+1)-1:0] rec_count
);

    localparam int IW = $clog2(DEPTH);

    logic [SEL_W-1:0] sel_d;
    logic [SEL_W-1:0] sel_q;
    stk_act_e         act;
    logic             wr_en;
    logic [IW-1:0]    wr_idx;
    logic             clr_en;
    logic [IW-1:0]    clr_idx;

    always_comb begin
        sel_d = sel_q;
        if (sel_we) begin
            sel_d = sel_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    bts_filter u_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel_q),
        .br_valid   (br_valid),
        .br_kind    (br_kind),
        .br_user    (br_user),
        .freeze     (freeze),
        .irq_freeze (irq_freeze),
        .act        (act)
    );

    bts_pointer #(.DEPTH(DEPTH)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .act     (act),
        .top_o   (top_idx),
        .cnt_o   (rec_count),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .clr_en  (clr_en),
        .clr_idx (clr_idx)
    );

    bts_entries #(.AW(AW), .DEPTH(DEPTH)) u_ent (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_from (br_from),
        .wr_to   (br_to),
        .clr_en  (clr_en),
        .clr_idx (clr_idx),
        .rd_idx  (rd_idx),
        .rd_from (rd_from),
        .rd_to   (rd_to),
        .rd_vld  (rd_vld)
    );

    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> ($stable(top_idx) && $stable(rec_count))); // R9
    AST_IRQ_HOLD_RING: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_freeze && !sel_q[SB_CHAIN]) |=> ($stable(top_idx) && $stable(rec_count))); // R10
    AST_CHAIN_RET_POPS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q[SB_CHAIN] && br_valid && br_kind == 3'd5 && !freeze && !sel_q[SB_RET]
         && !(br_user ? sel_q[SB_USER] : sel_q[SB_KERN]) && rec_count != '0)
        |=> rec_count == $past(rec_count) - 1'b1); // R6

endmodule

// File: tb/sim_branch_trail_stack.sv
`timescale 1ns/1ps
module sim_branch_trail_stack;

    localparam int AW    = 32;
    localparam int DEPTH = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          br_valid = 1'b0;
    logic [AW-1:0] br_from = '0;
    logic [AW-1:0] br_to = '0;
    logic [2:0]    br_kind = '0;
    logic          br_user = 1'b0;
    logic          sel_we = 1'b0;
    logic [9:0]    sel_wdata = '0;
    logic          freeze = 1'b0;
    logic          irq_freeze = 1'b0;
    logic [3:0]    rd_idx = '0;
    logic [AW-1:0] rd_from;
    logic [AW-1:0] rd_to;
    logic          rd_vld;
    logic [3:0]    top_idx;
    logic [4:0]    rec_count;

    always #10 clk = ~clk;

    branch_trail_stack #(.AW(AW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_from(br_from), .br_to(br_to),
        .br_kind(br_kind), .br_user(br_user), .sel_we(sel_we), .sel_wdata(sel_wdata),
        .freeze(freeze), .irq_freeze(irq_freeze), .rd_idx(rd_idx), .rd_from(rd_from),
        .rd_to(rd_to), .rd_vld(rd_vld), .top_idx(top_idx), .rec_count(rec_count)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [AW-1:0] m_from [DEPTH];
    logic [AW-1:0] m_to [DEPTH];
    bit            m_v [DEPTH];
    int            m_top;
    int            m_cnt;
    logic [9:0]    m_sel;
    logic [AW-1:0] e_from;
    logic [AW-1:0] e_to;
    bit            e_vld;
    int            addr_n = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit keeps(input logic [9:0] s, input logic [2:0] k, input bit u);
        int b;
        if (k == 3'd7) return 1'b0;
        if (u ? s[1] : s[0]) return 1'b0;
        case (k)
            3'd0: b = 2;
            3'd1: b = 7;
            3'd2: b = 6;
            3'd3: b = 3;
            3'd4: b = 4;
            3'd5: b = 5;
            default: b = 8;
        endcase
        return !s[b];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) begin
            m_from[i] = '0; m_to[i] = '0; m_v[i] = 1'b0;
        end
        m_top = DEPTH - 1; m_cnt = 0; m_sel = '0;
    endtask

    task automatic model_clock();
        bit halted;
        e_from = m_from[rd_idx]; e_to = m_to[rd_idx]; e_vld = m_v[rd_idx];
        halted = freeze | (irq_freeze & !m_sel[9]);
        if (br_valid && !halted && keeps(m_sel, br_kind, br_user)) begin
            if (!m_sel[9] || br_kind == 3'd3 || br_kind == 3'd4) begin
                m_top = (m_top + 1) % DEPTH;
                m_from[m_top] = br_from; m_to[m_top] = br_to; m_v[m_top] = 1'b1;
                if (m_cnt < DEPTH) m_cnt++;
            end else if (br_kind == 3'd5 && m_cnt > 0) begin
                m_v[m_top] = 1'b0;
                m_top = (m_top + DEPTH - 1) % DEPTH;
                m_cnt--;
            end
        end
        if (sel_we) m_sel = sel_wdata;
    endtask

    task automatic cycle(input string tag);
        @(posedge clk);
        model_clock();
        @(negedge clk);
        chk(top_idx == 4'(m_top), tag, "top_idx", longint'(top_idx), longint'(m_top));
        chk(rec_count == 5'(m_cnt), tag, "rec_count", longint'(rec_count), longint'(m_cnt));
        chk(rd_from == e_from && rd_to == e_to && rd_vld == e_vld, "R11", "read entry",
            {rd_vld, rd_from}, {e_vld, e_from});
    endtask

    task automatic idle();
        br_valid = 1'b0; sel_we = 1'b0; freeze = 1'b0; irq_freeze = 1'b0;
    endtask

    task automatic br(input logic [2:0] k, input bit u, input string tag);
        addr_n++;
        br_valid = 1'b1; br_kind = k; br_user = u;
        br_from = 32'h1000_0000 + 32'(addr_n);
        br_to   = 32'h2000_0000 + 32'(addr_n);
        cycle(tag);
        br_valid = 1'b0;
    endtask

    task automatic wsel(input logic [9:0] v);
        sel_we = 1'b1; sel_wdata = v;
        cycle("R2");
        sel_we = 1'b0;
    endtask

    task automatic read_all(input string tag);
        for (int i = 0; i < DEPTH; i++) begin
            rd_idx = 4'(i);
            cycle(tag);
            chk(rd_vld == m_v[i], tag, "entry valid", longint'(rd_vld), longint'(m_v[i]));
        end
    endtask

    task automatic do_reset();
        idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int t0;
        void'($urandom(32'h5eed_0b17));
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk(top_idx == 4'd15, "R1", "top after reset", longint'(top_idx), 15);
        chk(rec_count == 5'd0, "R1", "count after reset", longint'(rec_count), 0);
        read_all("R1");

        // R3 ring fill and overwrite
        for (int i = 0; i < 20; i++) br(3'(i % 7), bit'(i % 2), "R3");
        chk(rec_count == 5'd16, "R3", "saturated count", longint'(rec_count), 16);
        chk(top_idx == 4'd3, "R3", "wrapped top", longint'(top_idx), 3);
        read_all("R3");

        // R4 return logged in ring mode
        br(3'd5, 1'b0, "R4");
        rd_idx = top_idx;
        cycle("R4");
        chk(rd_from == 32'h1000_0000 + 32'(addr_n) && rd_vld, "R4", "return record",
            longint'(rd_from), longint'(32'h1000_0000 + 32'(addr_n)));

        // R2 filtering
        wsel(10'h001);
        t0 = m_top;
        br(3'd0, 1'b0, "R2");
        chk(top_idx == 4'(t0), "R2", "kernel suppressed", longint'(top_idx), t0);
        br(3'd0, 1'b1, "R2");
        wsel(10'h040);
        t0 = m_top;
        br(3'd2, 1'b1, "R2");
        chk(top_idx == 4'(t0), "R2", "indirect jump suppressed", longint'(top_idx), t0);
        br(3'd7, 1'b1, "R2");
        chk(top_idx == 4'(t0), "R2", "kind 7 dropped", longint'(top_idx), t0);
        br(3'd1, 1'b0, "R2");

        // R10 interrupt hold in ring mode, R9 debugger hold
        t0 = m_top;
        irq_freeze = 1'b1; br(3'd3, 1'b0, "R10"); irq_freeze = 1'b0;
        chk(top_idx == 4'(t0), "R10", "ring irq hold", longint'(top_idx), t0);
        freeze = 1'b1; br(3'd4, 1'b0, "R9");
        rd_idx = 4'(t0); cycle("R9"); freeze = 1'b0;
        chk(top_idx == 4'(t0), "R9", "freeze hold", longint'(top_idx), t0);

        // Call-chain mode
        do_reset();
        wsel(10'h200);
        br(3'd3, 1'b0, "R5"); br(3'd4, 1'b1, "R5"); br(3'd3, 1'b0, "R5");
        chk(rec_count == 5'd3, "R5", "three calls", longint'(rec_count), 3);
        br(3'd0, 1'b0, "R8"); br(3'd1, 1'b0, "R8"); br(3'd2, 1'b1, "R8"); br(3'd6, 1'b0, "R8");
        chk(rec_count == 5'd3, "R8", "flow branches dropped", longint'(rec_count), 3);
        irq_freeze = 1'b1; br(3'd5, 1'b0, "R10"); irq_freeze = 1'b0;
        chk(rec_count == 5'd2, "R10", "irq hold ignored", longint'(rec_count), 2);
        freeze = 1'b1; br(3'd5, 1'b0, "R9"); freeze = 1'b0;
        chk(rec_count == 5'd2, "R9", "freeze in chain", longint'(rec_count), 2);
        br(3'd5, 1'b0, "R6"); br(3'd5, 1'b1, "R6");
        chk(top_idx == 4'd15 && rec_count == 5'd0, "R6", "chain emptied",
            longint'({top_idx, rec_count}), longint'({4'd15, 5'd0}));
        br(3'd5, 1'b0, "R7");
        chk(top_idx == 4'd15 && rec_count == 5'd0, "R7", "empty return ignored",
            longint'({top_idx, rec_count}), longint'({4'd15, 5'd0}));
        read_all("R6");

        // Overflowed chain walked back past entry 0
        for (int i = 0; i < 18; i++) br(3'(3 + (i % 2)), 1'b0, "R5");
        for (int i = 0; i < 16; i++) br(3'd5, 1'b0, "R6");
        chk(top_idx == 4'd1 && rec_count == 5'd0, "R6", "overflow unwound",
            longint'({top_idx, rec_count}), longint'({4'd1, 5'd0}));
        br(3'd5, 1'b1, "R7");
        read_all("R6");

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            sel_we = 1'b0;
            if ($urandom % 64 == 0) begin
                sel_we = 1'b1;
                case ($urandom % 4)
                    0: sel_wdata = 10'h000;
                    1: sel_wdata = 10'h200;
                    2: sel_wdata = 10'h200 | (10'($urandom) & 10'h1C7);
                    default: sel_wdata = 10'($urandom);
                endcase
            end
            br_valid = ($urandom % 4) != 0;
            br_kind = ($urandom % 2 == 1) ? 3'(3 + $urandom % 3) : 3'($urandom % 8);
            br_user = 1'($urandom);
            br_from = 32'($urandom);
            br_to = 32'($urandom);
            freeze = ($urandom % 16) == 0;
            irq_freeze = ($urandom % 12) == 0;
            rd_idx = 4'($urandom);
            cycle(m_sel[9] ? "R6" : "R3");
        end
        idle();
        read_all("R3");

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule